// File: doc/BRIEF.md
# Serial Successive-Approximation ADC Sequencer

This block is the digital control core of a four-input, 12-bit successive-approximation converter. An active-low chip select enables it, and it runs from a free-running clock. At the start of each 16-clock frame it latches one of four input channels and raises a one-cycle sample strobe. It then resolves the result one bit per clock, from the most significant bit down. It does this by driving a trial code to an external DAC and reading a single comparator bit back. The result leaves the block one bit at a time on a serial data pin, which has its own output enable.

A two-bit mode input picks the operation. One-shot mode converts once, sends the word most significant bit first, and then holds the data pin low until chip select is cycled. Continuous LSB-first mode latches each finished word and sends it least significant bit first while the next conversion runs. Continuous MSB-first mode sends each bit as soon as it is resolved, frame after frame. The fourth code disables the block. The analog sample-and-hold, the comparator and the DAC sit outside the block.

Top module: `sar_adc_seq`

## Requirements
- R1: `chan_o` shows the channel latched at the start of the current frame. `chan_sel_i` = 0, 1, 2 or 3 selects input 0, 1, 2 or 3, and the converted word comes from that input.
- R2: `mode_i` decodes as follows: 2'b00 is one-shot MSB-first, 2'b01 is continuous LSB-first, 2'b11 is continuous MSB-first, and 2'b10 is disabled.
- R3: `samp_o` is high for exactly one clock at the start of each frame. The first data bit is driven three clocks after `samp_o` falls, so it appears four clocks after `samp_o` rose.
- R4: Each bit trial sets the bit under test in `dac_code_o`. The bit is kept unless `cmp_below_i` is high, in which case it is cleared. The final word equals the sampled input code.
- R5: In one-shot mode, the 12 bits go out MSB first in frame clocks 4 to 15. After that, `dout_o` is driven low and no further frame starts until `cs_ni` goes high and then low again.
- R6: In continuous LSB-first mode, `dout_oe_o` stays low through the first frame. The first word's LSB appears 20 clocks after the first clock edge that sees `cs_ni` low, and the word is sent LSB first while the next conversion runs.
- R7: In continuous MSB-first mode, frames repeat every 16 clocks, and each frame's word is sent MSB first within that same frame.
- R8: In the continuous modes, `chan_sel_i` is re-sampled at the start of every frame. A change made during one frame selects the input for the next frame.
- R9: While `cs_ni` is high, `samp_oe_o` and `dout_oe_o` are low (high impedance) and the sequence returns to idle.
- R10: With mode 2'b10 applied at start, no frame starts and both output enables stay low.
- R11: After reset, `samp_o`, `samp_oe_o`, `dout_o` and `dout_oe_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; high stops and floats the outputs |
| chan_sel_i | input | 2 | Channel select, sampled at each frame start |
| mode_i | input | 2 | Operating mode code |
| cmp_below_i | input | 1 | Comparator: held input is below the DAC level |
| chan_o | output | 2 | Channel routed to the sample-and-hold |
| dac_code_o | output | 12 | Trial code for the DAC |
| samp_o | output | 1 | Sample strobe, one clock per frame |
| samp_oe_o | output | 1 | Output enable for `samp_o` |
| dout_o | output | 1 | Serial result bit |
| dout_oe_o | output | 1 | Output enable for `dout_o` |

## Verification
The assertions watch the strobe width, the four-clock gap from strobe to the opening of the data window, the floating of both outputs under a high chip select, and the disabled code keeping the block idle. These are checked on every cycle. Other behaviours need modelled analog values and need the word read back bit by bit, so only the bench scenarios show them. These are the result values, the bit order in each mode, the 20-clock latency of the LSB-first mode, the low hold after a one-shot conversion, and a channel change taking effect one frame later.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_CONT_LSB = 2'b01,
    MODE_OFF      = 2'b10,
    MODE_CONT_MSB = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_HALT = 2'b10
  } state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int LEAD  = 3,
  parameter int CH_W  = 2,
  localparam int FRAME = LEAD + 1 + RES_W,
  localparam int PH_W  = $clog2(FRAME),
  localparam int IDX_W = $clog2(RES_W),
  localparam int LAST_TRIAL = LEAD + RES_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic [1:0]       mode_i,
  input  logic [CH_W-1:0]  chan_sel_i,
  output state_e           state_o,
  output mode_e            mode_q_o,
  output logic [CH_W-1:0]  chan_q_o,
  output logic             frame_start_o,
  output logic             trial_en_o,
  output logic [IDX_W-1:0] trial_idx_o,
  output logic             last_trial_o,
  output logic             open_o,
  output logic             frame_end_o
);
  state_e            state_q;
  mode_e             mode_q;
  logic [CH_W-1:0]   chan_q;
  logic [PH_W-1:0]   ph_q;
  logic [PH_W-1:0]   offs;
  logic              run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_ONESHOT;
      chan_q  <= '0;
      ph_q    <= '0;
    end else if (cs_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (mode_e'(mode_i) != MODE_OFF) begin
          state_q <= ST_RUN;
          mode_q  <= mode_e'(mode_i);
          chan_q  <= chan_sel_i;
          ph_q    <= '0;
        end
        ST_RUN: begin
          if (ph_q == PH_W'(FRAME - 1)) begin
            ph_q <= '0;
            if (mode_q == MODE_ONESHOT) state_q <= ST_HALT;
            else chan_q <= chan_sel_i;   // re-sample for next frame
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign run           = (state_q == ST_RUN);
  assign offs          = PH_W'(LAST_TRIAL) - ph_q;
  assign frame_start_o = run && (ph_q == '0);
  assign trial_en_o    = run && (ph_q >= PH_W'(LEAD)) && (ph_q <= PH_W'(LAST_TRIAL));
  assign trial_idx_o   = IDX_W'(offs);
  assign last_trial_o  = run && (ph_q == PH_W'(LAST_TRIAL));
  assign open_o        = run && (ph_q == PH_W'(LEAD));
  assign frame_end_o   = run && (ph_q == PH_W'(FRAME - 1));
  assign state_o       = state_q;
  assign mode_q_o      = mode_q;
  assign chan_q_o      = chan_q;
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             frame_start_i,
  input  logic             trial_en_i,
  input  logic [IDX_W-1:0] trial_idx_i,
  input  logic             last_trial_i,
  input  logic             cmp_below_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_ok_o,
  output logic             bit_val_o
);
  logic [RES_W-1:0] sar_q, mask, sar_nxt;

  assign mask       = trial_en_i ? ({{(RES_W-1){1'b0}}, 1'b1} << trial_idx_i) : '0;
  assign dac_code_o = sar_q | mask;
  assign bit_val_o  = !cmp_below_i;
  assign sar_nxt    = cmp_below_i ? sar_q : dac_code_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q       <= '0;
      result_o    <= '0;
      result_ok_o <= 1'b0;
    end else if (idle_i) begin
      sar_q       <= '0;
      result_ok_o <= 1'b0;
    end else if (frame_start_i) begin
      sar_q <= '0;
    end else if (trial_en_i) begin
      sar_q <= sar_nxt;
      if (last_trial_i) begin
        result_o    <= sar_nxt;
        result_ok_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  mode_e            mode_i,
  input  logic             open_i,
  input  logic             frame_end_i,
  input  logic             trial_en_i,
  input  logic [IDX_W-1:0] trial_idx_i,
  input  logic             bit_val_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             result_ok_i,
  output logic             dout_o,
  output logic             out_on_o
);
  logic [IDX_W-1:0] lsb_idx;
  assign lsb_idx = IDX_W'(RES_W - 1) - trial_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o   <= 1'b0;
      out_on_o <= 1'b0;
    end else if (stop_i) begin
      dout_o   <= 1'b0;
      out_on_o <= 1'b0;
    end else begin
      if (trial_en_i)
        dout_o <= (mode_i == MODE_CONT_LSB) ? result_i[lsb_idx] : bit_val_i;
      else if (frame_end_i)
        dout_o <= 1'b0;
      if (open_i)
        out_on_o <= (mode_i != MODE_CONT_LSB) || result_ok_i;
      else if (frame_end_i)
        out_on_o <= (mode_i == MODE_ONESHOT);  // one-shot keeps driving low
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int LEAD  = 3,
  parameter int CH_W  = 2,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic [CH_W-1:0]  chan_sel_i,
  input  logic [1:0]       mode_i,
  input  logic             cmp_below_i,
  output logic [CH_W-1:0]  chan_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             samp_o,
  output logic             samp_oe_o,
  output logic             dout_o,
  output logic             dout_oe_o
);
  state_e           state;
  mode_e            mode_q;
  logic             frame_start, trial_en, last_trial, open, frame_end;
  logic [IDX_W-1:0] trial_idx;
  logic [RES_W-1:0] result;
  logic             result_ok, bit_val, out_on, idle;

  sar_seq_ctrl #(.RES_W(RES_W), .LEAD(LEAD), .CH_W(CH_W)) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .mode_i, .chan_sel_i,
    .state_o(state), .mode_q_o(mode_q), .chan_q_o(chan_o),
    .frame_start_o(frame_start), .trial_en_o(trial_en), .trial_idx_o(trial_idx),
    .last_trial_o(last_trial), .open_o(open), .frame_end_o(frame_end)
  );

  assign idle = (state == ST_IDLE);

  sar_core #(.RES_W(RES_W)) u_sar (
    .clk_i, .rst_ni, .idle_i(idle), .frame_start_i(frame_start),
    .trial_en_i(trial_en), .trial_idx_i(trial_idx), .last_trial_i(last_trial),
    .cmp_below_i, .dac_code_o, .result_o(result), .result_ok_o(result_ok),
    .bit_val_o(bit_val)
  );

  sar_out_shift #(.RES_W(RES_W)) u_out (
    .clk_i, .rst_ni, .stop_i(cs_ni || idle), .mode_i(mode_q), .open_i(open),
    .frame_end_i(frame_end), .trial_en_i(trial_en), .trial_idx_i(trial_idx),
    .bit_val_i(bit_val), .result_i(result), .result_ok_i(result_ok),
    .dout_o, .out_on_o(out_on)
  );

  assign samp_o    = frame_start;
  assign samp_oe_o = !cs_ni && !idle;
  assign dout_oe_o = !cs_ni && out_on;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic [1:0] mode_i,
  input logic       samp_o,
  input logic       samp_oe_o,
  input logic       dout_oe_o
);
  AST_SAMP_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o |=> !samp_o);  // R3
  AST_DATA_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dout_oe_o) && !cs_ni) |-> $past(samp_o, 4));  // R3
  AST_NO_DATA_AT_SAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o |=> !dout_oe_o);  // R3
  AST_CS_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!samp_oe_o && !dout_oe_o));  // R9
  AST_OFF_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!samp_oe_o && mode_i == 2'b10) |=> !samp_oe_o);  // R10
endmodule

bind sar_adc_seq sar_adc_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .mode_i(mode_i),
  .samp_o(samp_o), .samp_oe_o(samp_oe_o), .dout_oe_o(dout_oe_o)
);

// File: tb/tb_sar_adc_seq.sv
module tb_sar_adc_seq;
  localparam int RES_W = 12;
  // {mode[1:0], chan[1:0], value[11:0]}
  localparam logic [15:0] VEC [8] = '{
    {2'b00, 2'b00, 12'h000}, {2'b00, 2'b11, 12'hFFF},
    {2'b00, 2'b01, 12'h800}, {2'b11, 2'b10, 12'h7FF},
    {2'b11, 2'b00, 12'hA5C}, {2'b01, 2'b01, 12'h123},
    {2'b01, 2'b11, 12'h555}, {2'b01, 2'b10, 12'hF0F}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1;
  logic [1:0] chan_sel_i = 2'b00, mode_i = 2'b00;
  logic [RES_W-1:0] ain [4];
  logic cmp_below_i;
  logic [1:0] chan_o;
  logic [RES_W-1:0] dac_code_o;
  logic samp_o, samp_oe_o, dout_o, dout_oe_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;
  assign cmp_below_i = ain[chan_o] < dac_code_o;

  sar_adc_seq dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // waits for the strobe; on return the current negedge is frame clock 0
  task automatic wait_samp(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk_i);
      if (samp_o && samp_oe_o) seen = 1'b1;
    end
  endtask

  task automatic grab(input bit lsb, input int pre, output logic [RES_W-1:0] w, output bit oe_ok);
    oe_ok = 1'b1;
    repeat (pre) @(negedge clk_i);
    for (int i = 0; i < RES_W; i++) begin
      if (i > 0) @(negedge clk_i);
      if (!dout_oe_o) oe_ok = 1'b0;
      if (lsb) w[i] = dout_o; else w[RES_W-1-i] = dout_o;
    end
  endtask

  task automatic stop_cs();
    @(negedge clk_i);
    cs_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic start(input logic [1:0] m, input logic [1:0] c);
    mode_i = m; chan_sel_i = c;
    cs_ni = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [RES_W-1:0] w;
    bit seen, oe_ok, quiet;
    for (int k = 0; k < 4; k++) ain[k] = RES_W'(12'h111 * (k + 1));
    repeat (3) @(negedge clk_i);
    // R11: reset values
    chk(!samp_o && !samp_oe_o && !dout_o && !dout_oe_o, "R11 reset outputs",
        {samp_o, samp_oe_o, dout_o, dout_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VEC[v]) begin
      logic [1:0] m, c;
      logic [RES_W-1:0] val;
      {m, c, val} = VEC[v];
      ain[c] = val;
      start(m, c);
      wait_samp(seen);
      chk(seen, "R3 strobe seen", seen, 1);
      chk(chan_o == c, "R1 channel latched", chan_o, c);          // R1
      if (m == 2'b01) begin
        quiet = 1'b1;
        for (int t = 1; t < 20; t++) begin
          @(negedge clk_i);
          if (dout_oe_o) quiet = 1'b0;
          if (t == 16) chk(samp_o, "R6 second frame strobe", samp_o, 1);
        end
        chk(quiet, "R6 no data in first frame", !quiet, 0);
        grab(1'b1, 1, w, oe_ok);                                   // clocks 20..31
        chk(w == val && oe_ok, "R6 LSB-first word", w, val);
      end else begin
        grab(1'b0, 4, w, oe_ok);                                   // clocks 4..15
        chk(w == val && oe_ok, "R4 MSB-first word", w, val);
        @(negedge clk_i);                                          // clock 16
        if (m == 2'b00) begin
          chk(dout_oe_o && !dout_o && !samp_o, "R5 held low after word",
              {dout_oe_o, dout_o, samp_o}, 3'b100);
          wait_samp(seen);
          chk(!seen && dout_oe_o && !dout_o, "R5 no restart", seen, 0);
        end else begin
          chk(samp_o, "R7 next frame after 16 clocks", samp_o, 1);
          grab(1'b0, 4, w, oe_ok);
          chk(w == val && oe_ok, "R7 repeated word", w, val);
        end
      end
      stop_cs();
      chk(!samp_oe_o && !dout_oe_o, "R9 float with cs high", {samp_oe_o, dout_oe_o}, 0);
    end

    // R8: channel change during a continuous MSB-first frame
    ain[0] = 12'h3C1; ain[2] = 12'hC3E;
    start(2'b11, 2'b00);
    wait_samp(seen);
    @(negedge clk_i); @(negedge clk_i);
    chan_sel_i = 2'b10;
    grab(1'b0, 2, w, oe_ok);
    chk(w == 12'h3C1, "R8 old channel in current frame", w, 12'h3C1);
    @(negedge clk_i);
    chk(samp_o && chan_o == 2'b10, "R8 new channel next frame", chan_o, 2);
    grab(1'b0, 4, w, oe_ok);
    chk(w == 12'hC3E, "R8 new channel word", w, 12'hC3E);

    // R9: cs high in the middle of a frame
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    cs_ni = 1'b1;
    #1;
    chk(!samp_oe_o && !dout_oe_o, "R9 immediate float", {samp_oe_o, dout_oe_o}, 0);
    repeat (3) @(negedge clk_i);

    // R10 / R2: disabled mode code
    start(2'b10, 2'b01);
    quiet = 1'b1;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk_i);
      if (samp_o || samp_oe_o || dout_oe_o) quiet = 1'b0;
    end
    chk(quiet, "R10 disabled mode stays idle", !quiet, 0);
    chk(quiet, "R2 mode 2'b10 decodes as disabled", !quiet, 0);
    stop_cs();

    // R11: asynchronous reset mid-conversion
    start(2'b11, 2'b01);
    wait_samp(seen);
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    cs_ni = 1'b1;
    #1;
    chk(!samp_o && !dout_o && !dout_oe_o && !samp_oe_o, "R11 reset mid-run",
        {samp_o, dout_o, dout_oe_o, samp_oe_o}, 0);
    summary();
  end
endmodule